// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on a tick-enable input. The tick first passes through a selectable divider. The count is compared with a period register, and when a counted tick finds the two equal, the counter returns to zero instead of advancing. In that same cycle the block emits a single-cycle match pulse that other logic can use as a time base, for example a PWM generator or a serial shift clock.

The match events also drive a programmable event divider. Its output sets a sticky interrupt flag, and an interrupt request leaves the block only while both the flag and an enable bit are set.

Software reaches four byte-wide registers through a write port and a combinational read port:

| Address | Register | Contents |
|---|---|---|
| 0 | count | the counter value |
| 1 | period | the period value |
| 2 | control | bits [1:0] tick divider select, bit 2 run, bits [6:3] event divider select, bit 7 reserved and read as 0 |
| 3 | interrupt | bit 0 flag, bit 1 enable |

A freeze input stands for a low-power state. While it is high, no counting takes place.

Top module: `pmt_timer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control register reads 00h, and the flag, `irq` and `match_pulse` are 0.
- R2: Software can write the count (address 0), the period (address 1) and the control register (address 2) and read back the written value. Bit 7 of the control register always reads 0.
- R3: On a divided tick where count equals period, the count becomes 00h on that edge and `match_pulse` is 1 for that one cycle. On any other divided tick the count rises by one and wraps from FFh to 00h. One period therefore spans period+1 divided ticks.
- R4: The tick divider select in control bits [1:0] gives one count step per 1, 4, 16 or 64 enabled ticks for the codes 00, 01, 10 and 11.
- R5: When control bits [6:3] hold N, every (N+1)-th match event sets the flag.
- R6: The flag (address 3, bit 0) stays set until software writes 0 to bit 0. Writing 1 to bit 0 has no effect. If a divider output and a clearing write land in the same cycle, the flag stays set.
- R7: `irq` is 1 exactly when the flag and the enable bit (address 3, bit 1) are both 1.
- R8: While the control run bit (bit 2) is 0, the count holds its value.
- R9: While `freeze` is 1, the count holds its value, the period keeps its contents, and ticks are ignored. Counting resumes when `freeze` returns to 0.
- R10: A write to the count or to the control register clears the internal counts of both dividers.
- R11: A count write overrides both the increment and the clear-after-match in the same cycle. It suppresses that cycle's match pulse and match event.
- R12: `match_pulse` fires on every match, whatever the event divider setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| tick_en | input | 1 | count-enable tick before the divider |
| freeze | input | 1 | halts all counting while high |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | register write address |
| wr_data | input | 8 | register write data |
| rd_addr | input | 2 | register read address |
| rd_data | output | 8 | register read data (combinational) |
| match_pulse | output | 1 | one-cycle pulse on each period match |
| irq | output | 1 | interrupt request |

## Verification
The hardest situations to reach are the same-cycle collisions: a flag-clearing write on the very edge where a divider output sets the flag, and a count write on the very edge where a match would fire. The bench reaches both by starting the timer with a control write, which zeroes both dividers. From that edge the match edges are an exact, countable number of cycles away, so each write can be placed on the predicted edge. The divider clearing is shown the same way: the write lands part-way through a divided interval, and the bench checks that the next step moves later by the expected number of edges.

// File: rtl/pmt_pkg.sv
// Package: shared constants and register layout for the period-match timer.
// Assumes byte-wide registers and a 2-bit register address.
package pmt_pkg;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned PRE_SW = 2;
    localparam int unsigned PST_SW = 4;

    typedef enum logic [1:0] {
        A_COUNT  = 2'd0,
        A_PERIOD = 2'd1,
        A_CTRL   = 2'd2,
        A_IRQ    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              rsvd;
        logic [PST_SW-1:0] post_sel;
        logic              run;
        logic [PRE_SW-1:0] pre_sel;
    } ctrl_t;
endpackage

// File: rtl/pmt_prescaler.sv
// Module: tick divider. Passes one of every 4**sel enabled steps as a tick.
// Assumes sel changes only together with clr, so the count never exceeds the limit.
module pmt_prescaler #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned CW = 2 * ((1 << SEL_W) - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // limit = 4**sel - 1
    always_comb lim = CW'((32'd1 << (32'd2 * 32'(sel))) - 32'd1);

    assign tick = step && (cnt_q == lim);

    // divider count, cleared by reset or by a register write
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (step)      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/pmt_postscaler.sv
// Module: event divider. Emits one output event for every sel+1 input events.
// Assumes sel changes only together with clr.
module pmt_postscaler #(
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt_in,
    input  logic [SEL_W-1:0] sel,
    output logic             evt_out
);
    logic [SEL_W-1:0] cnt_q;

    assign evt_out = evt_in && (cnt_q == sel);

    // event count, cleared by reset or by a register write
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (evt_in)    cnt_q <= (cnt_q == sel) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/pmt_counter.sv
// Module: counter and period register with the equality comparator.
// Assumes tick is already divided. A count write wins over counting and clearing.
module pmt_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cnt,
    input  logic         wr_per,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic [W-1:0] period,
    output logic         match_evt
);
    assign match_evt = tick && !wr_cnt && (count == period);

    // counter: write, clear on match, or increment
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= '0;
        else if (wr_cnt)    count <= wr_data;
        else if (match_evt) count <= '0;
        else if (tick)      count <= count + 1'b1;
    end

    // period register, all ones after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      period <= '1;
        else if (wr_per) period <= wr_data;
    end
endmodule

// File: rtl/pmt_timer.sv
// Module: period-match timer top. Register decode, control, flag and interrupt.
// Assumes one write per cycle. Reads are combinational from the current state.
module pmt_timer
    import pmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             match_pulse,
    output logic             irq
);
    ctrl_t            ctrl_q;
    logic             flag_q;
    logic             ie_q;
    logic             wr_cnt, wr_per, wr_ctl, wr_irq;
    logic             flag_clr;
    logic             step, div_tick, match_evt, post_evt, clr_div;
    logic [CNT_W-1:0] count, period;

    assign wr_cnt   = wr_en && (wr_addr == A_COUNT);
    assign wr_per   = wr_en && (wr_addr == A_PERIOD);
    assign wr_ctl   = wr_en && (wr_addr == A_CTRL);
    assign wr_irq   = wr_en && (wr_addr == A_IRQ);
    assign flag_clr = wr_irq && !wr_data[0];
    assign clr_div  = wr_cnt || wr_ctl;
    assign step     = tick_en && ctrl_q.run && !freeze;

    pmt_prescaler #(.SEL_W(PRE_SW)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr_div), .step(step),
        .sel(ctrl_q.pre_sel), .tick(div_tick)
    );

    pmt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_per(wr_per),
        .wr_data(wr_data), .tick(div_tick), .count(count),
        .period(period), .match_evt(match_evt)
    );

    pmt_postscaler #(.SEL_W(PST_SW)) u_post (
        .clk(clk), .rst_n(rst_n), .clr(clr_div), .evt_in(match_evt),
        .sel(ctrl_q.post_sel), .evt_out(post_evt)
    );

    // control register; the reserved bit is held at 0
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_ctl) ctrl_q <= {1'b0, wr_data[CNT_W-2:0]};
    end

    // sticky flag: a divider output wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (post_evt) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (wr_irq) ie_q <= wr_data[1];
    end

    // registered one-cycle match pulse
    always_ff @(posedge clk) begin
        if (!rst_n) match_pulse <= 1'b0;
        else        match_pulse <= match_evt;
    end

    assign irq = flag_q && ie_q;

    // combinational read mux
    always_comb begin
        case (rd_addr)
            A_COUNT:  rd_data = count;
            A_PERIOD: rd_data = period;
            A_CTRL:   rd_data = ctrl_q;
            default:  rd_data = {{(CNT_W-2){1'b0}}, ie_q, flag_q};
        endcase
    end
endmodule

// File: rtl/pmt_checker.sv
// Module: assertion checker for pmt_timer, attached by bind.
// Assumes it sees the counter, period, flag and write decodes of the top.
module pmt_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         freeze,
    input logic         run,
    input logic         cnt_wr,
    input logic         flag_clr,
    input logic         flag,
    input logic         match_pulse,
    input logic [W-1:0] count,
    input logic [W-1:0] period
);
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (freeze && !cnt_wr) |=> count == $past(count)); // R9
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!run && !cnt_wr) |=> count == $past(count)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag && !flag_clr) |=> flag); // R6
    AST_ZERO_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n) match_pulse |-> count == '0); // R3
    AST_MATCH_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) match_pulse |-> $past(count) == $past(period)); // R3
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n) !cnt_wr |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0)); // R3
endmodule

bind pmt_timer pmt_checker #(.W(pmt_pkg::CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .run(ctrl_q.run),
    .cnt_wr(wr_cnt), .flag_clr(flag_clr), .flag(flag_q),
    .match_pulse(match_pulse), .count(count), .period(period)
);

// File: tb/pmt_timer_tb.sv
module pmt_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       freeze = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       match_pulse;
    logic       irq;
    int         n_checks = 0;
    int         n_errors = 0;

    localparam logic [1:0] AC = 2'd0, AP = 2'd1, AT = 2'd2, AI = 2'd3;

    always #10 clk = ~clk;

    pmt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .match_pulse(match_pulse), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic logic [7:0] ctl(input int pre, input int run, input int post);
        return {1'b0, 4'(post), 1'(run), 2'(pre)};
    endfunction

    // stop, load the period, zero the count, clear the flag and the enable
    task automatic setup(input logic [7:0] per);
        wr(AT, 8'h00);
        wr(AP, per);
        wr(AC, 8'h00);
        wr(AI, 8'h00);
    endtask

    task automatic t_reset();
        int v;
        rd(AC, v); check("R1 count", v, 8'h00);
        rd(AP, v); check("R1 period", v, 8'hFF);
        rd(AT, v); check("R1 ctrl", v, 8'h00);
        rd(AI, v); check("R1 flag", v, 0);
        check("R1 irq", int'(irq), 0);
        check("R1 match", int'(match_pulse), 0);
    endtask

    task automatic t_readwrite();
        int v;
        wr(AC, 8'hA5); rd(AC, v); check("R2 count rw", v, 8'hA5);
        wr(AP, 8'h3C); rd(AP, v); check("R2 period rw", v, 8'h3C);
        wr(AT, 8'hFB); rd(AT, v); check("R2 ctrl rw bit7 zero", v, 8'h7B);
        wr(AT, 8'h00);
    endtask

    task automatic t_match_period();
        int v;
        setup(8'd5);
        wr(AT, ctl(0, 1, 0));
        edges(5); rd(AC, v); check("R3 count at period", v, 5);
        check("R3 no early match", int'(match_pulse), 0);
        edges(1); rd(AC, v); check("R3 cleared after match", v, 0);
        check("R3 match pulse", int'(match_pulse), 1);
        edges(1); rd(AC, v); check("R3 restart", v, 1);
        check("R3 pulse one cycle", int'(match_pulse), 0);
        edges(4); check("R3 no match mid period", int'(match_pulse), 0);
        edges(1); check("R3 second match", int'(match_pulse), 1);
    endtask

    task automatic t_prescaler();
        int v;
        for (int s = 0; s < 4; s++) begin
            int dv = 1 << (2 * s);
            setup(8'hFF);
            wr(AT, ctl(s, 1, 0));
            edges(2 * dv - 1); rd(AC, v); check($sformatf("R4 sel %0d first", s), v, 1);
            edges(1); rd(AC, v); check($sformatf("R4 sel %0d second", s), v, 2);
        end
    endtask

    task automatic t_postscaler();
        int v;
        setup(8'd1);
        wr(AT, ctl(0, 1, 2));
        edges(2); check("R12 match with divider 3", int'(match_pulse), 1);
        rd(AI, v); check("R12 flag not yet", v & 1, 0);
        edges(3); rd(AI, v); check("R5 flag before third match", v & 1, 0);
        edges(1); rd(AI, v); check("R5 flag on third match", v & 1, 1);
    endtask

    task automatic t_flag_irq();
        int v;
        wr(AT, 8'h00);
        wr(AI, 8'h03); check("R7 irq flag and enable", int'(irq), 1);
        wr(AI, 8'h01); check("R7 irq disabled", int'(irq), 0);
        rd(AI, v); check("R6 writing 1 keeps flag", v & 1, 1);
        wr(AI, 8'h00); rd(AI, v); check("R6 write 0 clears", v & 1, 0);
        wr(AI, 8'h01); rd(AI, v); check("R6 writing 1 does not set", v & 1, 0);
    endtask

    task automatic t_flag_collision();
        int v;
        setup(8'd1);
        wr(AT, ctl(0, 1, 0));
        edges(1);
        wr(AI, 8'h00); rd(AI, v); check("R6 set beats clear", v & 1, 1);
        wr(AI, 8'h00); rd(AI, v); check("R6 clear without event", v & 1, 0);
    endtask

    task automatic t_run_hold();
        int v;
        setup(8'hFF);
        wr(AT, ctl(0, 1, 0));
        edges(4);
        wr(AT, ctl(0, 0, 0));
        rd(AC, v); check("R8 last count", v, 5);
        edges(10); rd(AC, v); check("R8 held while stopped", v, 5);
    endtask

    task automatic t_freeze();
        int v;
        setup(8'hFF);
        wr(AT, ctl(0, 1, 0));
        edges(3); rd(AC, v); check("R9 before freeze", v, 3);
        freeze = 1'b1;
        edges(10); rd(AC, v); check("R9 held in freeze", v, 3);
        rd(AP, v); check("R9 period kept", v, 8'hFF);
        freeze = 1'b0;
        edges(2); rd(AC, v); check("R9 resumes", v, 5);
    endtask

    task automatic t_div_clear();
        int v;
        setup(8'hFF);
        wr(AT, ctl(1, 1, 0));
        edges(2);
        wr(AC, 8'd10);
        edges(3); rd(AC, v); check("R10 count write clears tick divider", v, 10);
        edges(1); rd(AC, v); check("R10 step after full interval", v, 11);
        setup(8'd1);
        wr(AT, ctl(0, 1, 1));
        edges(2);
        wr(AT, ctl(0, 1, 1));
        edges(1); rd(AI, v); check("R10 ctrl write clears event divider", v & 1, 0);
        edges(2); rd(AI, v); check("R10 flag after two fresh matches", v & 1, 1);
    endtask

    task automatic t_write_priority();
        int v;
        setup(8'd3);
        wr(AT, ctl(0, 1, 0));
        edges(3); rd(AC, v); check("R11 at period", v, 3);
        wr(AC, 8'd7);
        rd(AC, v); check("R11 write beats clear", v, 7);
        check("R11 no match pulse", int'(match_pulse), 0);
        rd(AI, v); check("R11 no match event", v & 1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_readwrite();
        t_match_period();
        t_prescaler();
        t_postscaler();
        t_flag_irq();
        t_flag_collision();
        t_run_hold();
        t_freeze();
        t_div_clear();
        t_write_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule